// File: doc/BRIEF.md
# Port Change Monitor

This block watches four general-purpose input pins. It can filter each one against contact bounce, and it tells the host when any of them has changed. Each raw pin level first passes a two-stage synchroniser. When filtering is turned on for a port, the level is also qualified by a slow sample tick. The level that results, called the compared value, is what the host reads back. It is also what the change logic compares against a per-port snapshot. That snapshot is retaken every time the host reads the port's register.

A port whose compared value moves away from its snapshot raises a sticky change bit. If that port is also allowed to interrupt, the block pulls a latching active-low interrupt line. The interrupt is not raised in the middle of a host read sequence. It waits for the end of the sequence, and it is dropped if the host has already read the port concerned.

The register file and the serial protocol around the block supply several signals: the per-port mode bits, one-cycle read strobes, and the start, stop and abort markers of a read sequence. In return they collect the levels, the change bits and two global active-low status bits.

Top module: `port_change_monitor`

## Requirements
- R1: With filtering off for a port, its `port_level` bit follows the synchronised raw pin. A change on `port_raw` shows on `port_level` within four clock cycles.
- R2: The sample tick fires once every `TICK_DIV` cycles in which `osc_en` is high. With filtering on for a port, its stored level takes a new value only when two consecutive tick samples agree. A pulse on the pin that is shorter than one tick period never reaches `port_level` or the change bit.
- R3: Each port with `is_input` high has a change bit `port_trans[i]`. The bit sets when the port's compared value differs from the snapshot taken at the last read of that port. It stays set, even if the level returns to the snapshot, until that port is read.
- R4: A read strobe `rd_port[i]` does three things at once: it clears `port_trans[i]`, it retakes the snapshot, and it suppresses a change that arrives in the same cycle.
- R5: A port with `is_input` low holds its change bit at 0 and never causes an interrupt.
- R6: A change bit sets whatever the port's `irq_en` bit is. Only ports with `irq_en` high drive the interrupt.
- R7: `irq_n` is active low and latching. Once low, it stays low until any port is read.
- R8: While a read sequence is open (from `seq_start` up to `seq_stop`), a new enabled change does not pull `irq_n` low. The assertion is held back and made at the stop. It is discarded if the changed port was read before the stop.
- R9: `glob_trans_n` is low exactly when at least one `port_trans` bit is set. `irq_status_n` always equals `irq_n`.
- R10: `bus_abort` closes an open read sequence in the same way as a stop. It never releases an asserted `irq_n`.
- R11: After the synchronous reset, the outputs are as follows: `port_trans` is 0, `port_level` is 0, `glob_trans_n` is 1, `irq_status_n` is 1 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Slow time-base enable pulse |
| port_raw | input | NPORTS | Asynchronous pin levels |
| is_input | input | NPORTS | Port is in input mode |
| deb_en | input | NPORTS | Bounce filter on for the port |
| irq_en | input | NPORTS | Port may drive the interrupt |
| rd_port | input | NPORTS | One-cycle strobe: host read port i's register |
| seq_start | input | 1 | A host read sequence begins |
| seq_stop | input | 1 | Stop condition ends the sequence |
| bus_abort | input | 1 | Hardware bus reset; acts as a forced stop |
| port_level | output | NPORTS | Readback level (filtered or instantaneous) |
| port_trans | output | NPORTS | Sticky per-port change bits |
| glob_trans_n | output | 1 | Low when any change bit is set |
| irq_status_n | output | 1 | Interrupt status bit, equal to irq_n |
| irq_n | output | 1 | Latching active-low interrupt line |

## Verification
Two events can land in the same clock cycle and have to be settled by a rule: a read strobe for a port, and a change in that port's compared value. The bench lines the strobe up with the cycle in which the synchronised level first differs. It then expects no change bit, a deasserted interrupt and a snapshot equal to the new level, and a later steady pin produces no flag. A second pairing, an enabled change arriving while a read sequence is open, is judged on two points: the flag must set immediately, and the interrupt must stay high until the stop.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  typedef struct packed {
    logic is_input;
    logic deb_en;
    logic irq_en;
  } port_cfg_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pcm_tick.sv
module pcm_tick #(
  parameter int unsigned TICK_DIV = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_en,
  output logic tick
);
  localparam int unsigned CW = pcm_pkg::cnt_width(TICK_DIV);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (osc_en) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          tick  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
    end else begin
      st_q[0] <= d;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/pcm_port.sv
module pcm_port
  import pcm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_s,
  input  logic      tick,
  input  port_cfg_t cfg,
  input  logic      rd,
  output logic      level_q,
  output logic      trans_q,
  output logic      trans_nxt,
  output logic      irq_evt
);
  logic prev_q, deb_q, snap_q, cmp_v, differ;

  // bounce filter: two agreeing tick samples update the stored level
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      deb_q  <= 1'b0;
    end else if (tick) begin
      prev_q <= pin_s;
      if (pin_s == prev_q) deb_q <= pin_s;
    end
  end

  assign cmp_v  = cfg.deb_en ? deb_q : pin_s;
  assign differ = cmp_v != snap_q;

  always_comb begin
    trans_nxt = trans_q;
    if (!cfg.is_input || rd) trans_nxt = 1'b0;
    else if (differ)         trans_nxt = 1'b1;
  end

  // a fresh enabled change, not masked by a read of this port
  assign irq_evt = cfg.is_input & cfg.irq_en & differ & ~rd & ~trans_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= 1'b0;
      trans_q <= 1'b0;
      level_q <= 1'b0;
    end else begin
      level_q <= cmp_v;
      trans_q <= trans_nxt;
      if (!cfg.is_input || rd) snap_q <= cmp_v;
    end
  end
endmodule

// File: rtl/pcm_irq.sv
module pcm_irq #(
  parameter int unsigned NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] evt,
  input  logic [NPORTS-1:0] rd_port,
  input  logic              seq_start,
  input  logic              seq_stop,
  input  logic              bus_abort,
  output logic              irq_q
);
  logic              in_seq_q;
  logic [NPORTS-1:0] pend_q, pend_live;
  logic              close_seq, irq_d;

  assign close_seq = seq_stop | bus_abort;
  assign pend_live = (pend_q & ~rd_port) | evt;

  always_comb begin
    irq_d = irq_q;
    if (|rd_port) irq_d = 1'b0;
    if (in_seq_q) begin
      if (close_seq && (|pend_live)) irq_d = 1'b1;
    end else if (|evt) begin
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_seq_q <= 1'b0;
      pend_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (close_seq) begin
        in_seq_q <= 1'b0;
        pend_q   <= '0;
      end else begin
        if (seq_start) in_seq_q <= 1'b1;
        if (in_seq_q)  pend_q   <= pend_live;
        else           pend_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/port_change_monitor.sv
module port_change_monitor
  import pcm_pkg::*;
#(
  parameter int unsigned NPORTS      = 4,
  parameter int unsigned TICK_DIV    = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_en,
  input  logic [NPORTS-1:0] port_raw,
  input  logic [NPORTS-1:0] is_input,
  input  logic [NPORTS-1:0] deb_en,
  input  logic [NPORTS-1:0] irq_en,
  input  logic [NPORTS-1:0] rd_port,
  input  logic              seq_start,
  input  logic              seq_stop,
  input  logic              bus_abort,
  output logic [NPORTS-1:0] port_level,
  output logic [NPORTS-1:0] port_trans,
  output logic              glob_trans_n,
  output logic              irq_status_n,
  output logic              irq_n
);
  logic              tick;
  logic              irq_q;
  logic [NPORTS-1:0] pin_s, trans_nxt, evt;

  pcm_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .osc_en(osc_en), .tick(tick)
  );

  pcm_sync #(.W(NPORTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(port_raw), .q(pin_s)
  );

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    port_cfg_t cfg;
    assign cfg = '{is_input: is_input[i], deb_en: deb_en[i], irq_en: irq_en[i]};
    pcm_port u_port (
      .clk(clk), .rst(rst), .pin_s(pin_s[i]), .tick(tick), .cfg(cfg),
      .rd(rd_port[i]), .level_q(port_level[i]), .trans_q(port_trans[i]),
      .trans_nxt(trans_nxt[i]), .irq_evt(evt[i])
    );
  end

  pcm_irq #(.NPORTS(NPORTS)) u_irq (
    .clk(clk), .rst(rst), .evt(evt), .rd_port(rd_port),
    .seq_start(seq_start), .seq_stop(seq_stop), .bus_abort(bus_abort),
    .irq_q(irq_q)
  );

  always_ff @(posedge clk) begin
    if (rst) glob_trans_n <= 1'b1;
    else     glob_trans_n <= ~(|trans_nxt);
  end

  assign irq_n        = ~irq_q;
  assign irq_status_n = ~irq_q;
endmodule

// File: rtl/pcm_checker.sv
module pcm_checker #(
  parameter int unsigned NPORTS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NPORTS-1:0] is_input,
  input logic [NPORTS-1:0] rd_port,
  input logic              seq_start,
  input logic              seq_stop,
  input logic              bus_abort,
  input logic [NPORTS-1:0] port_trans,
  input logic              glob_trans_n,
  input logic              irq_status_n,
  input logic              irq_n
);
  logic ck_seq;

  always_ff @(posedge clk) begin
    if (rst)                        ck_seq <= 1'b0;
    else if (seq_stop || bus_abort) ck_seq <= 1'b0;
    else if (seq_start)             ck_seq <= 1'b1;
  end

  // R9
  status_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_status_n == irq_n);

  // R9
  glob_flag_chk: assert property (@(posedge clk) disable iff (rst)
    glob_trans_n == (port_trans == '0));

  // R5
  output_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((port_trans & ~$past(is_input)) == '0));

  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_port != '0) |=> ((port_trans & $past(rd_port)) == '0));

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(port_trans) & ~$past(rd_port) & $past(is_input) & ~port_trans) == '0));

  // R7
  irq_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && rd_port == '0) |=> !irq_n);

  // R8
  no_assert_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> (!$past(ck_seq) || $past(seq_stop) || $past(bus_abort)));
endmodule

bind port_change_monitor pcm_checker #(.NPORTS(NPORTS)) u_pcm_checker (
  .clk(clk), .rst(rst), .is_input(is_input), .rd_port(rd_port),
  .seq_start(seq_start), .seq_stop(seq_stop), .bus_abort(bus_abort),
  .port_trans(port_trans), .glob_trans_n(glob_trans_n),
  .irq_status_n(irq_status_n), .irq_n(irq_n)
);

// File: tb/test_port_change_monitor.sv
`timescale 1ns/1ps
module test_port_change_monitor;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_en = 1'b1;
  logic [N-1:0] port_raw = '0, is_input = '1, deb_en = '0, irq_en = 4'b0011, rd_port = '0;
  logic seq_start = 1'b0, seq_stop = 1'b0, bus_abort = 1'b0;
  logic [N-1:0] port_level, port_trans;
  logic glob_trans_n, irq_status_n, irq_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  port_change_monitor #(.NPORTS(N), .TICK_DIV(4), .SYNC_STAGES(2)) i_port_change_monitor (
    .clk(clk), .rst(rst), .osc_en(osc_en), .port_raw(port_raw), .is_input(is_input),
    .deb_en(deb_en), .irq_en(irq_en), .rd_port(rd_port), .seq_start(seq_start),
    .seq_stop(seq_stop), .bus_abort(bus_abort), .port_level(port_level),
    .port_trans(port_trans), .glob_trans_n(glob_trans_n),
    .irq_status_n(irq_status_n), .irq_n(irq_n)
  );

  // {raw[12:9], read mask[8:5], expected trans[4:1], expected irq asserted[0]}
  localparam logic [12:0] VEC [9] = '{
    {4'b0001, 4'b0001, 4'b0001, 1'b1},
    {4'b0001, 4'b0000, 4'b0000, 1'b0},
    {4'b0101, 4'b0100, 4'b0100, 1'b0},
    {4'b0101, 4'b0000, 4'b0000, 1'b0},
    {4'b0111, 4'b0000, 4'b0010, 1'b1},
    {4'b0101, 4'b0010, 4'b0010, 1'b1},
    {4'b1101, 4'b1111, 4'b1000, 1'b0},
    {4'b0000, 4'b1111, 4'b1101, 1'b1},
    {4'b0000, 4'b0000, 4'b0000, 1'b0}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_rd(input logic [N-1:0] m);
    rd_port = m;
    @(negedge clk);
    rd_port = '0;
  endtask

  task automatic pulse_start();
    seq_start = 1'b1; @(negedge clk); seq_start = 1'b0;
  endtask

  task automatic pulse_stop();
    seq_stop = 1'b1; @(negedge clk); seq_stop = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog R11 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    check("R11 reset port_trans", 32'(port_trans), 0);
    check("R11 reset port_level", 32'(port_level), 0);
    check("R11 reset glob_trans_n", 32'(glob_trans_n), 1);
    check("R11 reset irq_status_n", 32'(irq_status_n), 1);
    check("R11 reset irq_n", 32'(irq_n), 1);

    // vector walk: filters off, ports 0 and 1 may interrupt
    for (int v = 0; v < 9; v++) begin
      port_raw = VEC[v][12:9];
      wait_cyc(6);
      check($sformatf("R1 vec%0d level", v), 32'(port_level), 32'(VEC[v][12:9]));
      check($sformatf("R3 R6 vec%0d trans", v), 32'(port_trans), 32'(VEC[v][4:1]));
      check($sformatf("R7 vec%0d irq_n", v), 32'(irq_n), 32'(!VEC[v][0]));
      check($sformatf("R9 vec%0d glob", v), 32'(glob_trans_n), 32'(VEC[v][4:1] == 4'b0));
      check($sformatf("R9 vec%0d status", v), 32'(irq_status_n), 32'(!VEC[v][0]));
      if (VEC[v][8:5] != 4'b0) begin
        pulse_rd(VEC[v][8:5]);
        wait_cyc(2);
      end
    end

    // collision: read strobe in the cycle the synchronised level first differs
    port_raw = 4'b0001;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    pulse_rd(4'b0001);
    wait_cyc(4);
    check("R4 collision trans", 32'(port_trans), 0);
    check("R4 collision irq_n", 32'(irq_n), 1);
    check("R4 collision level", 32'(port_level), 1);

    // held-back interrupt inside a read sequence
    pulse_start();
    port_raw = 4'b0000;
    wait_cyc(6);
    check("R8 flag during sequence", 32'(port_trans), 1);
    check("R8 no irq during sequence", 32'(irq_n), 1);
    pulse_stop();
    wait_cyc(1);
    check("R8 irq at stop", 32'(irq_n), 0);
    bus_abort = 1'b1; @(negedge clk); bus_abort = 1'b0;
    wait_cyc(2);
    check("R10 abort keeps irq", 32'(irq_n), 0);
    pulse_rd(4'b0010);
    wait_cyc(1);
    check("R7 read of any port clears irq", 32'(irq_n), 1);
    pulse_rd(4'b0001);
    wait_cyc(1);

    // dropped: changed port read before the stop
    pulse_start();
    port_raw = 4'b0001;
    wait_cyc(6);
    pulse_rd(4'b0001);
    wait_cyc(2);
    pulse_stop();
    wait_cyc(3);
    check("R8 dropped irq", 32'(irq_n), 1);
    check("R8 dropped trans", 32'(port_trans), 0);

    // abort acting as stop releases a held-back interrupt
    pulse_start();
    port_raw = 4'b0000;
    wait_cyc(6);
    check("R8 held before abort", 32'(irq_n), 1);
    bus_abort = 1'b1; @(negedge clk); bus_abort = 1'b0;
    wait_cyc(1);
    check("R10 abort closes sequence", 32'(irq_n), 0);
    pulse_rd(4'b0001);
    wait_cyc(2);

    // output-mode port
    is_input = 4'b1110;
    port_raw = 4'b0001;
    wait_cyc(6);
    check("R5 output trans", 32'(port_trans), 0);
    check("R5 output irq_n", 32'(irq_n), 1);
    port_raw = 4'b0000;
    wait_cyc(6);
    is_input = 4'b1111;
    wait_cyc(4);
    check("R5 back to input quiet", 32'(port_trans), 0);

    // bounce filter on port 0
    deb_en = 4'b0001;
    wait_cyc(12);
    check("R2 filter idle level", 32'(port_level), 0);
    port_raw = 4'b0001; @(negedge clk); port_raw = 4'b0000;
    wait_cyc(20);
    check("R2 glitch level", 32'(port_level), 0);
    check("R2 glitch trans", 32'(port_trans), 0);
    port_raw = 4'b0001;
    wait_cyc(3);
    check("R2 not yet filtered", 32'(port_level), 0);
    wait_cyc(15);
    check("R2 filtered level", 32'(port_level), 1);
    check("R2 filtered trans", 32'(port_trans), 1);
    check("R2 filtered irq_n", 32'(irq_n), 0);
    pulse_rd(4'b0001);
    wait_cyc(2);
    check("R4 read after filter", 32'(port_trans), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule